// File: doc/BRIEF.md
# SDRAM refresh scheduler

This unit sits beside the main SDRAM controller and keeps the memory refreshed at the required rate. A free-running interval timer produces one refresh obligation per interval. The interval is the clock frequency (kHz) times the refresh window (64 ms) divided by the 8192 refreshes needed in that window, rounded down. Obligations that cannot be served at once are held in a saturating backlog of at most 8 entries. While the backlog holds at least one entry the unit raises a request to the controller. It then waits for a grant, which the controller gives once its current access has finished. With the bus granted, it closes every bank with a precharge-all, waits the precharge time, issues one auto refresh, waits the refresh cycle time and drops its request to hand the bus back.

The same handshake also covers self refresh. While the self-refresh request is held, the unit precharges all banks and, with every bank idle, issues the refresh command with the clock enable driven low. It keeps the clock enable low for as long as the request stays high. When the request is released it raises the clock enable and sends only no-operation commands for the exit time before it returns the bus. Because the memory refreshes itself during this period, the backlog is cleared on entry and the interval timer restarts from zero on exit.

Top module: `sdram_ref_sched`

## Requirements
- R1: While rst_ni is low and on the first cycle after it: req_o=0, cke_o=1, a10_o=0, cmd_o=NOP, where cmd_o is {cs_n,ras_n,cas_n,we_n} and NOP=4'b0111.
- R2: With no self-refresh request, req_o rises on the (REF_INTERVAL+1)-th rising edge after reset release and not before.
- R3: Without a pending request the unit drives only NOP, whatever gnt_i does. With req_o high it drives NOP until gnt_i is sampled high. On the next cycle it drives precharge-all, PRE=4'b0010 with a10_o=1. The controller holds gnt_i high until req_o falls.
- R4: The auto refresh command REF=4'b0001 follows the precharge-all by exactly T_RP_CYC cycles, with NOP in between.
- R5: req_o falls exactly T_RFC_CYC cycles after the REF command, with NOP in between, and stays low if no refresh is owed.
- R6: Refresh obligations not yet served accumulate up to BACKLOG_MAX (8); ones arriving while the backlog is full are dropped. Each served obligation gives one REF.
- R7: While sr_req_i is high, the unit precharges all banks and T_RP_CYC cycles later issues REF with cke_o=0 in that same cycle. It then keeps cke_o=0 and drives NOP for as long as sr_req_i stays high.
- R8: The cycle after sr_req_i is sampled low, cke_o returns to 1. The unit then drives NOP with req_o high for exactly T_XSR_CYC cycles and drops req_o.
- R9: Entering self refresh clears the backlog, and the interval timer is held during self refresh. After exit, req_o rises only on the (REF_INTERVAL+1)-th edge after req_o fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sr_req_i | input | 1 | Level request to enter and stay in self refresh |
| gnt_i | input | 1 | Controller grants the command bus to the scheduler |
| req_o | output | 1 | Scheduler requests or holds the command bus |
| cke_o | output | 1 | Clock enable to the memory |
| cmd_o | output | 4 | Command {cs_n,ras_n,cas_n,we_n} |
| a10_o | output | 1 | Address bit 10, high for precharge-all |

## Verification
On every cycle, the checker confirms several rules. Commands appear only while the bus is requested and granted. Every precharge carries a10_o high. Each REF is at least the precharge time after the last precharge and at least the refresh cycle time after the last REF. The clock enable falls only together with a REF command, and only NOP is driven while it stays low and through the exit window after it rises. Only the bench's scenarios can show the rest. One is the exact interval after reset and after self-refresh exit. Another is the backlog cap, seen when the grant is withheld for twelve intervals and the count of REFs that follow is compared. The last is that a backlog left pending at self-refresh entry does not survive the exit.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_PRE,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RFC,
    ST_SR_ENTER,
    ST_SR_HOLD,
    ST_SR_EXIT
  } seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int unsigned INTERVAL = 1296
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic tick_o
);
  localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(INTERVAL - 1));
  assign tick_o = last && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (hold_i)     cnt_q <= '0;
    else if (last)       cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdram_ref_backlog.sv
module sdram_ref_backlog #(
  parameter int unsigned MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  input  logic clr_i,
  output logic pend_o
);
  localparam int unsigned CW = $clog2(MAX + 1);

  logic [CW-1:0] cnt_q;

  assign pend_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && !dec_i) begin
      if (cnt_q != CW'(MAX)) cnt_q <= cnt_q + 1'b1;
    end else if (dec_i && !inc_i) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sdram_ref_seq.sv
module sdram_ref_seq
  import sdram_ref_pkg::*;
#(
  parameter int unsigned T_RP_CYC  = 3,   // minimum 2
  parameter int unsigned T_RFC_CYC = 10,  // minimum 2
  parameter int unsigned T_XSR_CYC = 12   // minimum 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pend_i,
  input  logic       sr_req_i,
  input  logic       gnt_i,
  output logic       req_o,
  output logic       cke_o,
  output logic [3:0] cmd_o,
  output logic       a10_o,
  output logic       ref_done_o,
  output logic       sr_enter_o,
  output logic       in_sr_o
);
  localparam int unsigned TM1  = (T_RP_CYC > T_RFC_CYC) ? T_RP_CYC : T_RFC_CYC;
  localparam int unsigned TMAX = (TM1 > T_XSR_CYC) ? TM1 : T_XSR_CYC;
  localparam int unsigned WW   = $clog2(TMAX + 1);

  seq_state_e    state_q, state_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          sr_mode_q, sr_mode_d;

  always_comb begin
    state_d   = state_q;
    wcnt_d    = wcnt_q;
    sr_mode_d = sr_mode_q;
    unique case (state_q)
      ST_IDLE: begin
        if (sr_req_i) begin
          state_d   = ST_REQ;
          sr_mode_d = 1'b1;
        end else if (pend_i) begin
          state_d   = ST_REQ;
          sr_mode_d = 1'b0;
        end
      end
      ST_REQ:      if (gnt_i) state_d = ST_PRE;
      ST_PRE: begin
        state_d = ST_WAIT_RP;
        wcnt_d  = WW'(T_RP_CYC - 1);
      end
      ST_WAIT_RP: begin
        if (wcnt_q == WW'(1)) state_d = sr_mode_q ? ST_SR_ENTER : ST_REF;
        else                  wcnt_d  = wcnt_q - 1'b1;
      end
      ST_REF: begin
        state_d = ST_WAIT_RFC;
        wcnt_d  = WW'(T_RFC_CYC - 1);
      end
      ST_WAIT_RFC: begin
        if (wcnt_q == WW'(1)) state_d = ST_IDLE;
        else                  wcnt_d  = wcnt_q - 1'b1;
      end
      ST_SR_ENTER: state_d = ST_SR_HOLD;
      ST_SR_HOLD: begin
        if (!sr_req_i) begin
          state_d = ST_SR_EXIT;
          wcnt_d  = WW'(T_XSR_CYC);
        end
      end
      ST_SR_EXIT: begin
        if (wcnt_q == WW'(1)) state_d = ST_IDLE;
        else                  wcnt_d  = wcnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      wcnt_q    <= '0;
      sr_mode_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      wcnt_q    <= wcnt_d;
      sr_mode_q <= sr_mode_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PRE:              cmd_o = CMD_PRE;
      ST_REF, ST_SR_ENTER: cmd_o = CMD_REF;
      default:             cmd_o = CMD_NOP;
    endcase
  end

  assign req_o      = (state_q != ST_IDLE);
  assign a10_o      = (state_q == ST_PRE);
  assign cke_o      = !((state_q == ST_SR_ENTER) || (state_q == ST_SR_HOLD));
  assign ref_done_o = (state_q == ST_REF);
  assign sr_enter_o = (state_q == ST_SR_ENTER);
  assign in_sr_o    = (state_q == ST_SR_ENTER) || (state_q == ST_SR_HOLD) ||
                      (state_q == ST_SR_EXIT);
endmodule

// File: rtl/sdram_ref_sched.sv
module sdram_ref_sched #(
  parameter int unsigned CLK_KHZ       = 166000,
  parameter int unsigned REF_WINDOW_MS = 64,
  parameter int unsigned REF_COUNT     = 8192,
  parameter int unsigned T_RP_CYC      = 3,
  parameter int unsigned T_RFC_CYC     = 10,
  parameter int unsigned T_XSR_CYC     = 12,
  parameter int unsigned BACKLOG_MAX   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sr_req_i,
  input  logic       gnt_i,
  output logic       req_o,
  output logic       cke_o,
  output logic [3:0] cmd_o,
  output logic       a10_o
);
  localparam int unsigned REF_INTERVAL = CLK_KHZ * REF_WINDOW_MS / REF_COUNT;

  logic tick, pend, ref_done, sr_enter, in_sr;

  sdram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (in_sr),
    .tick_o (tick)
  );

  sdram_ref_backlog #(.MAX(BACKLOG_MAX)) u_backlog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (tick),
    .dec_i  (ref_done),
    .clr_i  (sr_enter),
    .pend_o (pend)
  );

  sdram_ref_seq #(
    .T_RP_CYC  (T_RP_CYC),
    .T_RFC_CYC (T_RFC_CYC),
    .T_XSR_CYC (T_XSR_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (pend),
    .sr_req_i   (sr_req_i),
    .gnt_i      (gnt_i),
    .req_o      (req_o),
    .cke_o      (cke_o),
    .cmd_o      (cmd_o),
    .a10_o      (a10_o),
    .ref_done_o (ref_done),
    .sr_enter_o (sr_enter),
    .in_sr_o    (in_sr)
  );
endmodule

// File: rtl/sdram_ref_sched_chk.sv
module sdram_ref_sched_chk #(
  parameter int unsigned T_RP_CYC  = 3,
  parameter int unsigned T_RFC_CYC = 10,
  parameter int unsigned T_XSR_CYC = 12
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       gnt_i,
  input logic       req_o,
  input logic       cke_o,
  input logic [3:0] cmd_o,
  input logic       a10_o
);
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;
  localparam int unsigned PW = $clog2(T_RP_CYC + 1);
  localparam int unsigned FW = $clog2(T_RFC_CYC + 1);
  localparam int unsigned XW = $clog2(T_XSR_CYC + 1);

  logic [PW-1:0] since_pre;
  logic [FW-1:0] since_ref;
  logic [XW-1:0] since_rise;
  logic          cke_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_pre  <= '0;
      since_ref  <= FW'(T_RFC_CYC);
      since_rise <= XW'(T_XSR_CYC);
      cke_q      <= 1'b1;
    end else begin
      cke_q <= cke_o;
      if (cmd_o == PRE)                     since_pre <= PW'(1);
      else if (since_pre < PW'(T_RP_CYC))   since_pre <= since_pre + 1'b1;
      if (cmd_o == REF)                     since_ref <= FW'(1);
      else if (since_ref < FW'(T_RFC_CYC))  since_ref <= since_ref + 1'b1;
      if (cke_o && !cke_q)                  since_rise <= XW'(1);
      else if (since_rise < XW'(T_XSR_CYC)) since_rise <= since_rise + 1'b1;
    end
  end

  assert_cmd_owned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != NOP) |-> (req_o && gnt_i));

  assert_pre_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == PRE) |-> a10_o);

  assert_rp_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == REF) |-> (since_pre >= PW'(T_RP_CYC)));

  assert_rfc_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == REF) |-> (since_ref >= FW'(T_RFC_CYC)));

  assert_cke_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (cmd_o == REF));

  assert_sr_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && !cke_q) |-> (cmd_o == NOP && req_o));

  assert_xsr_nop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o && (!cke_q || since_rise < XW'(T_XSR_CYC))) |-> (cmd_o == NOP && req_o));
endmodule

bind sdram_ref_sched sdram_ref_sched_chk #(
  .T_RP_CYC  (T_RP_CYC),
  .T_RFC_CYC (T_RFC_CYC),
  .T_XSR_CYC (T_XSR_CYC)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .gnt_i  (gnt_i),
  .req_o  (req_o),
  .cke_o  (cke_o),
  .cmd_o  (cmd_o),
  .a10_o  (a10_o)
);

// File: tb/sdram_ref_sched_tb.sv
`timescale 1ns/1ps
module sdram_ref_sched_tb;
  localparam int unsigned CLK_KHZ = 5120;          // gives an interval of 40 clocks
  localparam int unsigned N       = CLK_KHZ * 64 / 8192;
  localparam int unsigned T_RP    = 3;
  localparam int unsigned T_RFC   = 7;
  localparam int unsigned T_XSR   = 9;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;

  // {req_o, cmd_o} per cycle after grant, for T_RP=3, T_RFC=7
  localparam logic [4:0] SEQ_TAB [12] = '{
    5'b1_0010, 5'b1_0111, 5'b1_0111, 5'b1_0001,
    5'b1_0111, 5'b1_0111, 5'b1_0111, 5'b1_0111,
    5'b1_0111, 5'b1_0111, 5'b0_0111, 5'b0_0111
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sr_req_i = 1'b0;
  logic       gnt_i = 1'b0;
  logic       req_o, cke_o, a10_o;
  logic [3:0] cmd_o;

  int n_chk = 0;
  int n_bad = 0;

  sdram_ref_sched #(
    .CLK_KHZ(CLK_KHZ), .REF_WINDOW_MS(64), .REF_COUNT(8192),
    .T_RP_CYC(T_RP), .T_RFC_CYC(T_RFC), .T_XSR_CYC(T_XSR), .BACKLOG_MAX(8)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sr_req_i(sr_req_i), .gnt_i(gnt_i),
    .req_o(req_o), .cke_o(cke_o), .cmd_o(cmd_o), .a10_o(a10_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_reset();
    rst_ni   = 1'b0;
    gnt_i    = 1'b0;
    sr_req_i = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int refs;
    int bad;
    // R1 reset state
    repeat (2) @(negedge clk_i);
    check(req_o == 1'b0, "R1 req in reset", req_o, 0);
    check(cke_o == 1'b1, "R1 cke in reset", cke_o, 1);
    check(cmd_o == NOP && a10_o == 1'b0, "R1 cmd in reset", {a10_o, cmd_o}, NOP);
    do_reset();
    @(negedge clk_i);
    check(req_o == 1'b0 && cmd_o == NOP && cke_o, "R1 first cycle", {req_o, cke_o, cmd_o}, {2'b01, NOP});

    // R2 interval: already one edge consumed
    repeat (N - 1) @(posedge clk_i);
    @(negedge clk_i);
    check(req_o == 1'b0, "R2 before interval", req_o, 0);
    @(posedge clk_i); @(negedge clk_i);
    check(req_o == 1'b1, "R2 at interval", req_o, 1);

    // R3 wait for grant
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      if (cmd_o != NOP || !req_o) bad++;
    end
    check(bad == 0, "R3 no command before grant", bad, 0);
    gnt_i = 1'b1;
    // R3/R4/R5 table walk
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i);
      check({req_o, cmd_o} == SEQ_TAB[i], (i == 0) ? "R3 precharge" : (i == 3) ? "R4 refresh" : "R5 sequence",
            {req_o, cmd_o}, SEQ_TAB[i]);
      if (i == 0) check(a10_o == 1'b1, "R3 a10 on precharge", a10_o, 1);
    end
    gnt_i = 1'b0;

    // R6 backlog cap: 12 intervals withheld, 4 more while granted
    do_reset();
    repeat (12 * N + 5) @(posedge clk_i);
    @(negedge clk_i);
    check(req_o == 1'b1, "R6 request while withheld", req_o, 1);
    gnt_i = 1'b1;
    refs = 0;
    repeat (4 * N + 15) begin
      @(negedge clk_i);
      if (cmd_o == REF) refs++;
    end
    check(refs == 12, "R6 refreshes after backlog", refs, 12);
    gnt_i = 1'b0;

    // R3 grant without request; then R7/R8/R9 self refresh
    do_reset();
    gnt_i = 1'b1;
    bad = 0;
    repeat (10) begin
      @(negedge clk_i);
      if (cmd_o != NOP || req_o) bad++;
    end
    check(bad == 0, "R3 grant without request", bad, 0);
    gnt_i = 1'b0;
    repeat (2 * N + 1 - 10) @(posedge clk_i);
    @(negedge clk_i);
    check(req_o == 1'b1, "R9 backlog of two pending", req_o, 1);
    sr_req_i = 1'b1;
    gnt_i    = 1'b1;
    repeat (2 * T_RP + T_RFC + 3) @(negedge clk_i);
    check(cke_o == 1'b0 && cmd_o == REF, "R7 self refresh entry", {cke_o, cmd_o}, {1'b0, REF});
    bad = 0;
    repeat (3 * N) begin
      @(negedge clk_i);
      if (cke_o || cmd_o != NOP) bad++;
    end
    check(bad == 0, "R7 held in self refresh", bad, 0);
    sr_req_i = 1'b0;
    bad = 0;
    repeat (T_XSR) begin
      @(negedge clk_i);
      if (!cke_o || cmd_o != NOP || !req_o) bad++;
    end
    check(bad == 0, "R8 exit window", bad, 0);
    @(negedge clk_i);
    check(req_o == 1'b0 && cke_o == 1'b1, "R8 release after exit", {req_o, cke_o}, 2'b01);
    bad = 0;
    repeat (N) begin
      @(negedge clk_i);
      if (req_o) bad++;
    end
    check(bad == 0, "R9 backlog cleared", bad, 0);
    @(negedge clk_i);
    check(req_o == 1'b1, "R9 interval restarted", req_o, 1);

    finish_run();
  end
endmodule